// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Per-Pin Interrupts

This block is a general-purpose I/O controller for a parameterised number of pins (fewer than 32), reached through a plain word-wide register port (valid, write, word address, write data, combinational read data). It keeps an output latch and a direction register. It passes the pad levels through a two-stage synchronizer. For every pin it can raise an interrupt on a level or on an edge. All pins share one registered interrupt line.

The output latch is never rewritten as a whole word. Software writes ones to a set location to drive pins high, and ones to a clear location to drive them low. Two pins owned by different agents therefore never need a read-modify-write. Each pin has its own type and polarity bits, which select one of four detections: high level, low level, rising edge or falling edge. A detected condition reaches the interrupt line only when both the pin's enable bit and its mask bit are 1. A build parameter selects whether a direction bit of 1 turns the pad driver on or makes the pin an input.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output latch, the direction, enable, type, polarity, mask and latched-edge state are all zero. `irq` is 0. With `DIR_IS_INPUT`=0 `pad_oe` is all zeros, and with `DIR_IS_INPUT`=1 it is all ones.
- R2: A write to word 3 (byte 0x0C) sets every output-latch bit whose data bit is 1. A write to word 4 (byte 0x10) clears every latch bit whose data bit is 1. Bits written as 0 keep their value. A read of word 3 or word 4 returns the latch, which drives `pad_out`.
- R3: A read of word 1 (byte 0x04) returns the pad levels after two flops of synchronization. A change on `pad_in` ahead of clock edge k is visible from edge k+1 on. Writes to word 1 have no effect.
- R4: Word 0 (byte 0x00) is a read/write direction register. With `DIR_IS_INPUT`=0, `pad_oe` equals the register. With `DIR_IS_INPUT`=1, `pad_oe` is its bitwise inverse.
- R5: Words 5, 6 and 7 (bytes 0x14, 0x18, 0x1C) hold the enable, type and polarity bits. A pin whose type bit is 0 is edge-sensitive. With polarity 1 it latches its pending bit on a synchronized 0→1 step, and with polarity 0 on a 1→0 step. It latches only while its enable bit is 1. The pending bits read at word 8 (byte 0x20).
- R6: For a pin whose type bit is 1, the pending bit equals enable AND (synchronized level == polarity bit). It follows the level with no latching.
- R7: Writing 1 to a bit of word 8 clears that pin's latched edge. Zeros written leave it alone. If a qualifying edge arrives in the same cycle, the edge wins. Switching a pin to level type discards its latched edge.
- R8: `irq` is a flop holding the OR over all pins of pending AND enable AND mask (word 9, byte 0x24). It responds one cycle after the pending state.
- R9: Register bits at and above `NPINS` read as 0, and write data there is dropped. Word addresses with no register (such as word 2 or words 10 and up) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 6 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Output latch value |
| pad_oe | output | NPINS | Pad driver enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the controller with `NPINS`=12 and `DIR_IS_INPUT`=1. With 12 pins, 20 unused upper bits in every register can be written with ones and read back as zeros. The inverted direction sense makes the reset value of `pad_oe` all ones, which separates it from every other reset value. A reference model in the bench, running cycle by cycle, tracks every pin through rising, falling, high and low detection. It also covers clears issued in the same cycle as an edge, mask and enable gating, and a stretch of random pad activity.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;

  // word indexes of the register map
  localparam logic [ADDR_W-1:0] WIX_DIR  = 6'd0;
  localparam logic [ADDR_W-1:0] WIX_IN   = 6'd1;
  localparam logic [ADDR_W-1:0] WIX_SET  = 6'd3;
  localparam logic [ADDR_W-1:0] WIX_CLR  = 6'd4;
  localparam logic [ADDR_W-1:0] WIX_EN   = 6'd5;
  localparam logic [ADDR_W-1:0] WIX_TYPE = 6'd6;
  localparam logic [ADDR_W-1:0] WIX_POL  = 6'd7;
  localparam logic [ADDR_W-1:0] WIX_PEND = 6'd8;
  localparam logic [ADDR_W-1:0] WIX_MASK = 6'd9;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIR, SEL_IN, SEL_SET, SEL_CLR,
    SEL_EN, SEL_TYPE, SEL_POL, SEL_PEND, SEL_MASK
  } reg_sel_e;

  function automatic reg_sel_e decode_word(logic [ADDR_W-1:0] wix);
    case (wix)
      WIX_DIR:  return SEL_DIR;
      WIX_IN:   return SEL_IN;
      WIX_SET:  return SEL_SET;
      WIX_CLR:  return SEL_CLR;
      WIX_EN:   return SEL_EN;
      WIX_TYPE: return SEL_TYPE;
      WIX_POL:  return SEL_POL;
      WIX_PEND: return SEL_PEND;
      WIX_MASK: return SEL_MASK;
      default:  return SEL_NONE;
    endcase
  endfunction

  // step between two synchronized samples that matches the polarity
  function automatic logic edge_match(logic cur, logic prev, logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // level that matches the polarity
  function automatic logic level_match(logic cur, logic pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] sync_lvl,
  output logic [W-1:0] prev_lvl
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pad_in;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign sync_lvl = stab_q;
  assign prev_lvl = hist_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(meta_q) |=> (stab_q == $past(meta_q)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_lvl,
  input  logic [W-1:0] prev_lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] pend
);

  logic [W-1:0] lat_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign edge_hit[i] = edge_match(sync_lvl[i], prev_lvl[i], pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lat_q[i] <= 1'b0;
      else if (typ[i])                 lat_q[i] <= 1'b0;
      else if (edge_hit[i] && en[i])   lat_q[i] <= 1'b1;
      else if (clr[i])                 lat_q[i] <= 1'b0;
    end

    assign pend[i] = typ[i] ? (en[i] & level_match(sync_lvl[i], pol[i]))
                            : lat_q[i];

    // R5
    latch_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat_q[i]) |-> $past(edge_hit[i] && en[i] && !typ[i]));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !(edge_hit[i] && en[i])) |=> !lat_q[i]);
  end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_word_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [W-1:0]      sync_lvl,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      typ_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      pend_clr,
  output logic              wr_dir,
  output logic              wr_set,
  output logic              wr_clr
);

  reg_sel_e     sel;
  logic         wr_any;
  logic [W-1:0] wbits;
  logic         unused_wdata_hi;

  assign sel     = decode_word(bus_word_addr);
  assign wr_any  = bus_valid && bus_write;
  assign wbits   = bus_wdata[W-1:0];
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:W];

  assign wr_dir   = wr_any && (sel == SEL_DIR);
  assign wr_set   = wr_any && (sel == SEL_SET);
  assign wr_clr   = wr_any && (sel == SEL_CLR);
  assign pend_clr = (wr_any && (sel == SEL_PEND)) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr_any) begin
      case (sel)
        SEL_DIR:  dir_q  <= wbits;
        SEL_SET:  out_q  <= out_q | wbits;
        SEL_CLR:  out_q  <= out_q & ~wbits;
        SEL_EN:   en_q   <= wbits;
        SEL_TYPE: typ_q  <= wbits;
        SEL_POL:  pol_q  <= wbits;
        SEL_MASK: mask_q <= wbits;
        default:  ;
      endcase
    end
  end

  logic [W-1:0] rd_bits;
  always_comb begin
    case (sel)
      SEL_DIR:  rd_bits = dir_q;
      SEL_IN:   rd_bits = sync_lvl;
      SEL_SET,
      SEL_CLR:  rd_bits = out_q;
      SEL_EN:   rd_bits = en_q;
      SEL_TYPE: rd_bits = typ_q;
      SEL_POL:  rd_bits = pol_q;
      SEL_PEND: rd_bits = pend;
      SEL_MASK: rd_bits = mask_q;
      default:  rd_bits = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[W-1:0] = rd_bits;
  end

  // R2
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wbits)) == $past(wbits)));

  // R2
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wbits)) == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(out_q));

  // R9
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (bus_rdata[BUS_W-1:W] == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS        = 16,
  parameter bit DIR_IS_INPUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [5:0]        bus_word_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);

  logic [NPINS-1:0] sync_lvl, prev_lvl;
  logic [NPINS-1:0] dir_q, out_q, en_q, typ_q, pol_q, mask_q;
  logic [NPINS-1:0] pend, pend_clr, edge_hit;
  logic             wr_dir, wr_set, wr_clr;
  logic [NPINS-1:0] active;
  logic             irq_q;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .sync_lvl (sync_lvl),
    .prev_lvl (prev_lvl)
  );

  gpio_regfile #(.W(NPINS)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_word_addr (bus_word_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .sync_lvl      (sync_lvl),
    .pend          (pend),
    .dir_q         (dir_q),
    .out_q         (out_q),
    .en_q          (en_q),
    .typ_q         (typ_q),
    .pol_q         (pol_q),
    .mask_q        (mask_q),
    .pend_clr      (pend_clr),
    .wr_dir        (wr_dir),
    .wr_set        (wr_set),
    .wr_clr        (wr_clr)
  );

  gpio_irq_bank #(.W(NPINS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lvl (sync_lvl),
    .prev_lvl (prev_lvl),
    .en       (en_q),
    .typ      (typ_q),
    .pol      (pol_q),
    .clr      (pend_clr),
    .edge_hit (edge_hit),
    .pend     (pend)
  );

  if (DIR_IS_INPUT) begin : g_dir_inv
    assign pad_oe = ~dir_q;
  end else begin : g_dir_true
    assign pad_oe = dir_q;
  end

  assign pad_out = out_q;
  assign active  = pend & en_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |active;
  end
  assign irq = irq_q;

  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(pend & en_q & mask_q)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) && $stable(mask_q) |=> !irq);

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

  localparam int N   = 12;
  localparam bit INV = 1'b1;
  localparam logic [31:0] PM = (32'd1 << N) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_word_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_ctrl #(.NPINS(N), .DIR_IS_INPUT(INV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    live = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  logic [31:0] m_dir, m_out, m_en, m_typ, m_pol, m_msk, m_lat;
  logic [31:0] m_meta, m_now, m_old;
  logic        m_irq;

  function automatic logic [31:0] ref_pend();
    logic [31:0] r = 0;
    for (int i = 0; i < N; i++) begin
      if (m_typ[i]) r[i] = m_en[i] && (m_now[i] == m_pol[i]);
      else          r[i] = m_lat[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_read(logic [5:0] w);
    case (w)
      6'd0: return m_dir;
      6'd1: return m_now;
      6'd3, 6'd4: return m_out;
      6'd5: return m_en;
      6'd6: return m_typ;
      6'd7: return m_pol;
      6'd8: return ref_pend();
      6'd9: return m_msk;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_dir, m_out, m_en, m_typ, m_pol, m_msk, m_lat} = '0;
      {m_meta, m_now, m_old} = '0;
      m_irq = 1'b0;
    end else begin
      logic [31:0] p, nl, d;
      logic        wr;
      p  = ref_pend();
      wr = bus_valid && bus_write;
      d  = bus_wdata & PM;
      nl = m_lat;
      for (int i = 0; i < N; i++) begin
        logic up, dn, hit;
        up  = m_now[i] && !m_old[i];
        dn  = !m_now[i] && m_old[i];
        hit = m_pol[i] ? up : dn;
        if (m_typ[i])                                nl[i] = 1'b0;
        else if (hit && m_en[i])                     nl[i] = 1'b1;
        else if (wr && bus_word_addr == 6'd8 && d[i]) nl[i] = 1'b0;
      end
      m_irq = |(p & m_en & m_msk);
      m_lat = nl;
      if (wr) begin
        case (bus_word_addr)
          6'd0: m_dir = d;
          6'd3: m_out = m_out | d;
          6'd4: m_out = m_out & ~d;
          6'd5: m_en  = d;
          6'd6: m_typ = d;
          6'd7: m_pol = d;
          6'd9: m_msk = d;
          default: ;
        endcase
      end
      m_old  = m_now;
      m_now  = m_meta;
      m_meta = {{(32-N){1'b0}}, pad_in};
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the clock edges
  always begin
    @(negedge clk);
    #1;
    if (live && !done) begin
      check("R2 pad_out", {20'd0, pad_out}, m_out);
      check("R4 pad_oe", {20'd0, pad_oe}, INV ? (~m_dir & PM) : m_dir);
      check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
      if (bus_valid && !bus_write)
        check(cur_tag, bus_rdata, ref_read(bus_word_addr));
    end
  end

  task automatic wr(logic [5:0] w, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_word_addr = w; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [5:0] w, string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_valid = 1; bus_write = 0; bus_word_addr = w;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pads(logic [N-1:0] v, int hold);
    @(negedge clk);
    pad_in = v;
    repeat (hold) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state at the ports
    check("R1 pad_out", {20'd0, pad_out}, 32'd0);
    check("R1 pad_oe", {20'd0, pad_oe}, PM);
    check("R1 irq", {31'd0, irq}, 32'd0);
    live = 1'b1;
    for (int w = 0; w < 11; w++) rd(6'(w), "R1");

    // R4 direction register and inverted driver sense
    wr(6'd0, 32'h0000_0A5C);
    rd(6'd0, "R4");
    wr(6'd0, 32'hFFFF_F00F);
    rd(6'd0, "R4 R9");

    // R2 set and clear
    wr(6'd3, 32'h0000_0F0F);
    rd(6'd3, "R2");
    wr(6'd4, 32'h0000_000F);
    rd(6'd4, "R2");
    wr(6'd3, 32'hFFFF_FFFF);
    rd(6'd3, "R2 R9");
    wr(6'd4, 32'h0000_0000);
    rd(6'd4, "R2");
    wr(6'd4, 32'h0000_0AAA);

    // R3 synchronized input, write ignored
    pads(12'hA5A, 0);
    rd(6'd1, "R3");
    rd(6'd1, "R3");
    pads(12'h3C3, 0);
    rd(6'd1, "R3");
    wr(6'd1, 32'hFFFF_FFFF);
    rd(6'd1, "R3");

    // R5 edge detection, pins 0..5 rising, 6..11 falling
    pads(12'h000, 4);
    wr(6'd6, 32'h0);
    wr(6'd7, 32'h0000_003F);
    wr(6'd9, 32'h0000_0FFF);
    wr(6'd5, 32'h0000_0FFF);
    rd(6'd8, "R5");
    pads(12'h021, 3);
    rd(6'd8, "R5");
    pads(12'h020, 3);
    rd(6'd8, "R5");
    pads(12'hFC0, 3);
    pads(12'h000, 3);
    rd(6'd8, "R5");

    // R7 write-one-to-clear, zero bits untouched
    wr(6'd8, 32'h0000_0001);
    rd(6'd8, "R7");
    wr(6'd8, 32'hFFFF_FFFF);
    rd(6'd8, "R7");
    // clear in the same cycle as an edge: edge wins
    pads(12'h002, 1);
    wr(6'd8, 32'h0000_0002);
    rd(6'd8, "R7");

    // R8 mask and enable gating
    wr(6'd9, 32'h0);
    pads(12'h004, 3);
    rd(6'd8, "R8");
    wr(6'd9, 32'h0000_0004);
    rd(6'd8, "R8");
    wr(6'd5, 32'h0);
    rd(6'd8, "R8");
    wr(6'd8, 32'hFFFF_FFFF);
    pads(12'h008, 3);
    rd(6'd8, "R8");
    wr(6'd5, 32'h0000_0FFF);
    wr(6'd9, 32'h0000_0FFF);

    // R6 level detection, upper half high, lower half low
    wr(6'd7, 32'h0000_0FC0);
    wr(6'd6, 32'h0000_0FFF);
    rd(6'd8, "R6 R7");
    pads(12'hF0F, 3);
    rd(6'd8, "R6");
    pads(12'h0F0, 3);
    rd(6'd8, "R6");
    wr(6'd5, 32'h0000_0F00);
    rd(6'd8, "R6");

    // R9 unmapped words
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd10, 32'hFFFF_FFFF);
    rd(6'd2, "R9");
    rd(6'd10, "R9");
    rd(6'd63, "R9");

    // mixed random activity
    wr(6'd5, 32'h0000_0FFF);
    wr(6'd6, 32'h0000_0F00);
    wr(6'd7, 32'h0000_0A5A);
    for (int k = 0; k < 400; k++) begin
      pads(N'($urandom), $urandom_range(0, 2));
      case ($urandom_range(0, 3))
        0: wr(6'd8, $urandom);
        1: rd(6'd8, "R5 R6 R7");
        2: wr(6'd9, $urandom);
        default: rd(6'd1, "R3");
      endcase
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule